// File: doc/BRIEF.md
# Character LCD Initialization and Note Writer

This block drives an 8-bit parallel character display from a single received byte. After power is applied it waits out a power-on delay, then plays a fixed nine-step setup program into the panel. From then on it stays idle until a serial receiver reports a finished transfer. It captures the byte, treats it as a semitone index, turns it into a note name and an octave digit, and writes those characters to the first display position.

Two state machines share the work. The lower one owns the pins. It presents the data and register-select lines, raises the enable strobe for a set number of clocks, holds the lines stable around the strobe, and then waits out the panel's command execution time. The upper one decides what goes out next: the setup program first, then a cursor-home command followed by three characters for every accepted note. A busy output tells the sender when a new byte can be taken. All delays are derived from a clock-frequency parameter and microsecond parameters.

Top module: `char_lcd_ctrl`

## Requirements
- R1: When reset is released, `lcd_en` is low and `busy` is high. The first enable pulse rises no earlier than PWRUP_US microseconds of clock cycles after reset.
- R2: Setup issues exactly nine enable pulses. The first eight carry 0x30, 0x30, 0x30, 0x38, 0x08, 0x01, 0x06, 0x0C, in that order, with `lcd_rs` = 0.
- R3: The ninth setup pulse carries 0x74 with `lcd_rs` = 1. No further pulse follows until a byte is accepted.
- R4: The low time between the fall of one enable pulse and the rise of the next is at least LONG_US after the first pulse. It is at least CLEAR_US after the clear command (0x01 with `lcd_rs` = 0), and at least SHORT_US after every other pulse.
- R5: Every enable pulse stays high for exactly E_HIGH_CYC cycles. `lcd_d` and `lcd_rs` hold the same value in the cycle before the rise, for the whole pulse, and in the first cycle after the fall.
- R6: `rx_done` is accepted only while `busy` is low. `rx_byte` is captured in that same cycle, so later changes to `rx_byte` have no effect. `busy` is high in the next cycle.
- R7: Each accepted byte produces exactly four pulses. The first is 0x80 with `lcd_rs` = 0. It is followed by a letter, an accidental and a digit, each with `lcd_rs` = 1.
- R8: Let the index be the byte value. The index modulo 12 selects the letter in the order C, C, D, D, E, F, F, G, G, A, A, B, in ASCII. The accidental is '#' (0x23) for remainders 1, 3, 6, 8 and 10, and a space (0x20) otherwise. The digit is 0x30 plus the index divided by 12.
- R9: Indices above 119 are treated as 119, which gives 'B', space, '9'.
- R10: An `rx_done` pulse while `busy` is high is ignored. This holds both during setup and during a note write: the pulses issued and the characters written are unchanged.
- R11: `busy` falls only after the wait that follows the last pulse of a sequence. While `busy` is low no enable pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_byte | input | 8 | Byte from the serial receiver (semitone index) |
| rx_done | input | 1 | One-cycle strobe marking a completed transfer |
| lcd_d | output | 8 | Panel data bus |
| lcd_rs | output | 1 | Register select: 0 command, 1 character data |
| lcd_en | output | 1 | Enable strobe |
| busy | output | 1 | High while setting up or writing a note |

## Verification
`busy` responds in the cycle after an accepted `rx_done`, so the bench samples it at the next falling edge.

Enable pulses start only after the sequencer issue cycle and the setup cycle. A monitor therefore records each pulse at falling edges: its value at the rise, its width, and the low gap before it. No check relies on a fixed latency. Instead, each recorded gap is compared against the minimum wait that the previous command calls for.

Characters are compared only once `busy` has fallen, because the whole sequence has finished by then. Pulse indices are counted from the point where the byte was sent.

// File: rtl/lcd_ctrl_pkg.sv
// Shared types and constants for the character LCD controller.
// Assumes an 8-bit bus panel driven write-only (no busy-flag reads).
package lcd_ctrl_pkg;

    typedef enum logic [2:0] {
        PHY_POWERUP,
        PHY_IDLE,
        PHY_SETUP,
        PHY_PULSE,
        PHY_HOLD,
        PHY_WAIT
    } phy_state_t;

    typedef enum logic [2:0] {
        SEQ_WAIT_SPI,
        SEQ_INIT_ISSUE,
        SEQ_INIT_WAIT,
        SEQ_MAP,
        SEQ_WR_ISSUE,
        SEQ_WR_WAIT
    } seq_state_t;

    // Execution-time class that follows a command
    typedef enum logic [1:0] {
        GAP_SHORT,
        GAP_CLEAR,
        GAP_LONG
    } gap_cls_t;

    typedef struct packed {
        logic       rs;
        logic [7:0] code;
        gap_cls_t   gap;
    } lcd_cmd_t;

    localparam int         INIT_LEN    = 9;
    localparam int         NOTE_LEN    = 4;
    localparam logic [7:0] CMD_HOME    = 8'h80;
    localparam logic [7:0] ASCII_SHARP = 8'h23;
    localparam logic [7:0] ASCII_SPACE = 8'h20;
    localparam logic [7:0] ASCII_ZERO  = 8'h30;

    // Setup program: step index to command word
    function automatic lcd_cmd_t init_step(input logic [3:0] idx);
        lcd_cmd_t c;
        case (idx)
            4'd0:    c = '{rs: 1'b0, code: 8'h30, gap: GAP_LONG};
            4'd1:    c = '{rs: 1'b0, code: 8'h30, gap: GAP_SHORT};
            4'd2:    c = '{rs: 1'b0, code: 8'h30, gap: GAP_SHORT};
            4'd3:    c = '{rs: 1'b0, code: 8'h38, gap: GAP_SHORT};
            4'd4:    c = '{rs: 1'b0, code: 8'h08, gap: GAP_SHORT};
            4'd5:    c = '{rs: 1'b0, code: 8'h01, gap: GAP_CLEAR};
            4'd6:    c = '{rs: 1'b0, code: 8'h06, gap: GAP_SHORT};
            4'd7:    c = '{rs: 1'b0, code: 8'h0C, gap: GAP_SHORT};
            default: c = '{rs: 1'b1, code: 8'h74, gap: GAP_SHORT};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lcd_note_map.sv
// Converts a semitone index into three ASCII characters: letter,
// accidental ('#' or space) and octave digit. Purely combinational.
// Assumes MAX_IDX / 12 is at most 9 so the octave fits one digit.
module lcd_note_map #(
    parameter int MAX_IDX = 119
) (
    input  logic [7:0] idx,
    output logic [7:0] letter,
    output logic [7:0] accid,
    output logic [7:0] digit
);
    import lcd_ctrl_pkg::*;

    localparam int SEMIS = 12;

    int sat;
    int oct;
    int semi;

    // Saturate, split into octave and semitone, pick characters
    always_comb begin
        sat  = (int'(idx) > MAX_IDX) ? MAX_IDX : int'(idx);
        oct  = sat / SEMIS;
        semi = sat - oct * SEMIS;
        digit = ASCII_ZERO + 8'(oct);
        accid = ASCII_SPACE;
        case (semi)
            0:       letter = "C";
            1:       begin letter = "C"; accid = ASCII_SHARP; end
            2:       letter = "D";
            3:       begin letter = "D"; accid = ASCII_SHARP; end
            4:       letter = "E";
            5:       letter = "F";
            6:       begin letter = "F"; accid = ASCII_SHARP; end
            7:       letter = "G";
            8:       begin letter = "G"; accid = ASCII_SHARP; end
            9:       letter = "A";
            10:      begin letter = "A"; accid = ASCII_SHARP; end
            default: letter = "B";
        endcase
    end

    // R9: the digit must stay a decimal character after saturation
    always_comb begin
        p_digit_range_r9: assert (digit >= ASCII_ZERO && digit <= ASCII_ZERO + 8'd9);
    end

endmodule

// File: rtl/lcd_phy.sv
// Low-level pin driver. It waits out the power-on delay, then for each
// command: sets up D/RS for one cycle, raises E for E_HIGH_CYC cycles,
// holds D/RS one cycle, and waits the execution time of the command's class.
// Assumes every derived cycle count is at least 1.
module lcd_phy #(
    parameter int CLK_HZ     = 50_000_000,
    parameter int PWRUP_US   = 20000,
    parameter int LONG_US    = 5000,
    parameter int CLEAR_US   = 2000,
    parameter int SHORT_US   = 50,
    parameter int E_HIGH_CYC = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  lcd_ctrl_pkg::lcd_cmd_t  cmd,
    output logic                    ready,
    output logic                    done,
    output logic [7:0]              lcd_d,
    output logic                    lcd_rs,
    output logic                    lcd_en
);
    import lcd_ctrl_pkg::*;

    localparam int CYC_US    = CLK_HZ / 1_000_000;
    localparam int PWRUP_CYC = CYC_US * PWRUP_US;
    localparam int LONG_CYC  = CYC_US * LONG_US;
    localparam int CLEAR_CYC = CYC_US * CLEAR_US;
    localparam int SHORT_CYC = CYC_US * SHORT_US;
    localparam int MAX_A     = (PWRUP_CYC > LONG_CYC) ? PWRUP_CYC : LONG_CYC;
    localparam int MAX_B     = (CLEAR_CYC > SHORT_CYC) ? CLEAR_CYC : SHORT_CYC;
    localparam int MAX_C     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CYC   = (MAX_C > E_HIGH_CYC) ? MAX_C : E_HIGH_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    phy_state_t       st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] wait_len;
    logic [7:0]       d_q;
    logic             rs_q;
    gap_cls_t         gap_q;

    // Select the execution wait for the command in flight
    always_comb begin
        case (gap_q)
            GAP_LONG:  wait_len = CNT_W'(LONG_CYC);
            GAP_CLEAR: wait_len = CNT_W'(CLEAR_CYC);
            default:   wait_len = CNT_W'(SHORT_CYC);
        endcase
    end

    // Pin-timing state machine with a shared down-counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PHY_POWERUP;
            cnt_q <= CNT_W'(PWRUP_CYC - 1);
            d_q   <= '0;
            rs_q  <= 1'b0;
            gap_q <= GAP_SHORT;
        end else begin
            case (st_q)
                PHY_POWERUP: begin
                    if (cnt_q == '0) st_q <= PHY_IDLE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                PHY_IDLE: begin
                    if (start) begin
                        d_q   <= cmd.code;
                        rs_q  <= cmd.rs;
                        gap_q <= cmd.gap;
                        st_q  <= PHY_SETUP;
                    end
                end
                PHY_SETUP: begin
                    st_q  <= PHY_PULSE;
                    cnt_q <= CNT_W'(E_HIGH_CYC - 1);
                end
                PHY_PULSE: begin
                    if (cnt_q == '0) st_q <= PHY_HOLD;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                PHY_HOLD: begin
                    st_q  <= PHY_WAIT;
                    cnt_q <= wait_len - 1'b1;
                end
                PHY_WAIT: begin
                    if (cnt_q == '0) st_q <= PHY_IDLE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                default: st_q <= PHY_IDLE;
            endcase
        end
    end

    assign ready  = (st_q == PHY_IDLE);
    assign done   = (st_q == PHY_WAIT) && (cnt_q == '0);
    assign lcd_en = (st_q == PHY_PULSE);
    assign lcd_d  = d_q;
    assign lcd_rs = rs_q;

    // Checker state: length of the current high run of E
    int unsigned en_run;
    always_ff @(posedge clk) begin
        if (!rst_n)      en_run <= 0;
        else if (lcd_en) en_run <= en_run + 1;
        else             en_run <= 0;
    end

    // R5: bus lines frozen while E is high and on the cycle after it falls
    p_bus_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_en || $fell(lcd_en)) |-> ($stable(lcd_d) && $stable(lcd_rs)));

    // R5: E high run never exceeds, and on its fall equals, E_HIGH_CYC
    p_en_not_long_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_en |-> (en_run < E_HIGH_CYC));
    p_en_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_en) |-> (en_run == E_HIGH_CYC));

    // R11: a new command is only taken when the driver is idle
    p_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (st_q == PHY_IDLE));

endmodule

// File: rtl/lcd_seq.sv
// Mid-level sequencer. It comes up waiting for serial input; once the
// driver leaves power-up it plays the nine-step setup program. Afterwards
// each accepted byte is captured, mapped, and written as home + 3 chars.
// Assumes rx_done is a one-cycle strobe after a complete transfer.
module lcd_seq (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              rx_byte,
    input  logic                    rx_done,
    input  logic                    phy_ready,
    input  logic                    phy_done,
    input  logic [7:0]              map_letter,
    input  logic [7:0]              map_accid,
    input  logic [7:0]              map_digit,
    output logic [7:0]              note_idx,
    output logic                    start,
    output lcd_ctrl_pkg::lcd_cmd_t  cmd,
    output logic                    busy
);
    import lcd_ctrl_pkg::*;

    localparam logic [3:0] INIT_LAST = 4'(INIT_LEN - 1);
    localparam logic [3:0] NOTE_LAST = 4'(NOTE_LEN - 1);

    seq_state_t st_q;
    logic [3:0] step_q;
    logic       init_done_q;
    logic [7:0] note_q;
    logic [7:0] let_q;
    logic [7:0] acc_q;
    logic [7:0] dig_q;
    logic       in_init;

    assign in_init  = (st_q == SEQ_INIT_ISSUE) || (st_q == SEQ_INIT_WAIT);
    assign note_idx = note_q;

    // Pick the command word for the current step
    always_comb begin
        if (in_init) begin
            cmd = init_step(step_q);
        end else begin
            case (step_q)
                4'd0:    cmd = '{rs: 1'b0, code: CMD_HOME, gap: GAP_SHORT};
                4'd1:    cmd = '{rs: 1'b1, code: let_q,    gap: GAP_SHORT};
                4'd2:    cmd = '{rs: 1'b1, code: acc_q,    gap: GAP_SHORT};
                default: cmd = '{rs: 1'b1, code: dig_q,    gap: GAP_SHORT};
            endcase
        end
    end

    assign start = ((st_q == SEQ_INIT_ISSUE) || (st_q == SEQ_WR_ISSUE)) && phy_ready;
    assign busy  = !((st_q == SEQ_WAIT_SPI) && init_done_q);

    // Ordering state machine: setup program, then one write per byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= SEQ_WAIT_SPI;
            step_q      <= '0;
            init_done_q <= 1'b0;
            note_q      <= '0;
            let_q       <= '0;
            acc_q       <= '0;
            dig_q       <= '0;
        end else begin
            case (st_q)
                SEQ_WAIT_SPI: begin
                    if (!init_done_q && phy_ready) begin
                        step_q <= '0;
                        st_q   <= SEQ_INIT_ISSUE;
                    end else if (init_done_q && rx_done) begin
                        note_q <= rx_byte;
                        st_q   <= SEQ_MAP;
                    end
                end
                SEQ_INIT_ISSUE: begin
                    if (phy_ready) st_q <= SEQ_INIT_WAIT;
                end
                SEQ_INIT_WAIT: begin
                    if (phy_done) begin
                        if (step_q == INIT_LAST) begin
                            init_done_q <= 1'b1;
                            st_q        <= SEQ_WAIT_SPI;
                        end else begin
                            step_q <= step_q + 1'b1;
                            st_q   <= SEQ_INIT_ISSUE;
                        end
                    end
                end
                SEQ_MAP: begin
                    let_q  <= map_letter;
                    acc_q  <= map_accid;
                    dig_q  <= map_digit;
                    step_q <= '0;
                    st_q   <= SEQ_WR_ISSUE;
                end
                SEQ_WR_ISSUE: begin
                    if (phy_ready) st_q <= SEQ_WR_WAIT;
                end
                SEQ_WR_WAIT: begin
                    if (phy_done) begin
                        if (step_q == NOTE_LAST) begin
                            st_q <= SEQ_WAIT_SPI;
                        end else begin
                            step_q <= step_q + 1'b1;
                            st_q   <= SEQ_WR_ISSUE;
                        end
                    end
                end
                default: st_q <= SEQ_WAIT_SPI;
            endcase
        end
    end

    // R6: busy can only go high because a transfer was just accepted
    p_busy_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(rx_done));

    // R10: a strobe seen while busy leaves the captured byte untouched
    p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rx_done) |=> $stable(note_q));

    // R11: nothing is issued to the driver while idle
    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !start);

    // R3: setup runs once and is never repeated
    p_init_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_q |=> (init_done_q && !in_init));

endmodule

// File: rtl/char_lcd_ctrl.sv
// Top level of the character LCD controller: sequencer, note mapper and
// pin driver. Assumes rx_byte is valid in the cycle rx_done is high.
module char_lcd_ctrl #(
    parameter int CLK_HZ     = 50_000_000,
    parameter int PWRUP_US   = 20000,
    parameter int LONG_US    = 5000,
    parameter int CLEAR_US   = 2000,
    parameter int SHORT_US   = 50,
    parameter int E_HIGH_CYC = 12,
    parameter int MAX_IDX    = 119
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] rx_byte,
    input  logic       rx_done,
    output logic [7:0] lcd_d,
    output logic       lcd_rs,
    output logic       lcd_en,
    output logic       busy
);
    import lcd_ctrl_pkg::*;

    lcd_cmd_t   cmd;
    logic       start;
    logic       phy_ready;
    logic       phy_done;
    logic [7:0] note_idx;
    logic [7:0] map_letter;
    logic [7:0] map_accid;
    logic [7:0] map_digit;

    lcd_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_byte    (rx_byte),
        .rx_done    (rx_done),
        .phy_ready  (phy_ready),
        .phy_done   (phy_done),
        .map_letter (map_letter),
        .map_accid  (map_accid),
        .map_digit  (map_digit),
        .note_idx   (note_idx),
        .start      (start),
        .cmd        (cmd),
        .busy       (busy)
    );

    lcd_note_map #(.MAX_IDX(MAX_IDX)) u_map (
        .idx    (note_idx),
        .letter (map_letter),
        .accid  (map_accid),
        .digit  (map_digit)
    );

    lcd_phy #(
        .CLK_HZ     (CLK_HZ),
        .PWRUP_US   (PWRUP_US),
        .LONG_US    (LONG_US),
        .CLEAR_US   (CLEAR_US),
        .SHORT_US   (SHORT_US),
        .E_HIGH_CYC (E_HIGH_CYC)
    ) u_phy (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .cmd    (cmd),
        .ready  (phy_ready),
        .done   (phy_done),
        .lcd_d  (lcd_d),
        .lcd_rs (lcd_rs),
        .lcd_en (lcd_en)
    );

endmodule

// File: tb/char_lcd_ctrl_tb_top.sv
module char_lcd_ctrl_tb_top;

    localparam int T_CLK_HZ = 1_000_000;
    localparam int T_PWRUP  = 1000;
    localparam int T_LONG   = 5000;
    localparam int T_CLEAR  = 2000;
    localparam int T_SHORT  = 50;
    localparam int T_EHIGH  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_done = 1'b0;
    logic [7:0] lcd_d;
    logic       lcd_rs;
    logic       lcd_en;
    logic       busy;

    always #2 clk = ~clk;

    char_lcd_ctrl #(
        .CLK_HZ(T_CLK_HZ), .PWRUP_US(T_PWRUP), .LONG_US(T_LONG),
        .CLEAR_US(T_CLEAR), .SHORT_US(T_SHORT), .E_HIGH_CYC(T_EHIGH)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_done(rx_done),
        .lcd_d(lcd_d), .lcd_rs(lcd_rs), .lcd_en(lcd_en), .busy(busy)
    );

    int n_chk = 0;
    int n_pass = 0;

    task automatic check(input bit ok, input string req, input int act,
                         input int exp, input string what);
        n_chk++;
        if (ok) n_pass++;
        else $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    endtask

    // Pulse monitor, sampled at falling edges
    int         cyc = 0;
    int         rel_cyc = 0;
    int         n_pulses = 0;
    logic [7:0] pd  [0:511];
    logic       prs [0:511];
    int         prise [0:511];
    logic       prev_en = 1'b0;
    logic [7:0] prev_d = 8'h00;
    logic       prev_rs = 1'b0;
    int         hi_cnt = 0;
    int         last_fall = 0;
    int         setup_bad = 0;
    int         hold_bad = 0;
    int         width_bad = 0;
    int         gap_bad = 0;
    int         busy_bad = 0;

    function automatic int min_gap(input int idx);
        if (idx == 0) return T_LONG;
        if (pd[idx] == 8'h01 && prs[idx] == 1'b0) return T_CLEAR;
        return T_SHORT;
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (lcd_en && !prev_en) begin
                if (lcd_d !== prev_d || lcd_rs !== prev_rs) setup_bad++;
                if (!busy) busy_bad++;
                if (n_pulses > 0 && (cyc - last_fall) < min_gap(n_pulses - 1)) gap_bad++;
                pd[n_pulses]    = lcd_d;
                prs[n_pulses]   = lcd_rs;
                prise[n_pulses] = cyc;
                n_pulses++;
                hi_cnt = 1;
            end else if (lcd_en) begin
                hi_cnt++;
                if (lcd_d !== prev_d || lcd_rs !== prev_rs) hold_bad++;
            end else if (prev_en) begin
                if (lcd_d !== prev_d || lcd_rs !== prev_rs) hold_bad++;
                if (hi_cnt != T_EHIGH) width_bad++;
                last_fall = cyc;
            end
        end
        prev_en = lcd_en;
        prev_d  = lcd_d;
        prev_rs = lcd_rs;
    end

    function automatic void exp_note(input logic [7:0] v, output logic [7:0] l,
                                     output logic [7:0] a, output logic [7:0] g);
        int s;
        int m;
        s = (v > 8'd119) ? 119 : int'(v);
        m = s % 12;
        case (m)
            0, 1:    l = "C";
            2, 3:    l = "D";
            4:       l = "E";
            5, 6:    l = "F";
            7, 8:    l = "G";
            9, 10:   l = "A";
            default: l = "B";
        endcase
        a = (m == 1 || m == 3 || m == 6 || m == 8 || m == 10) ? 8'h23 : 8'h20;
        g = 8'(48 + s / 12);
    endfunction

    task automatic wait_idle();
        int t;
        t = 0;
        @(negedge clk);
        while (busy !== 1'b0 && t < 40000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic send_note(input logic [7:0] v, input bit poke);
        int base;
        logic [7:0] l;
        logic [7:0] a;
        logic [7:0] g;
        string rq;
        wait_idle();
        base = n_pulses;
        rx_byte = v;
        rx_done = 1'b1;
        @(negedge clk);
        rx_done = 1'b0;
        rx_byte = ~v;                              // R6: late change ignored
        check(busy === 1'b1, "R6", int'(busy), 1, "busy after accepted strobe");
        if (poke) begin
            for (int t = 0; t < 2000 && n_pulses < base + 2; t++) @(negedge clk);
            rx_byte = v ^ 8'h0D;                   // R10: strobe while busy
            rx_done = 1'b1;
            @(negedge clk);
            rx_done = 1'b0;
        end
        wait_idle();
        exp_note(v, l, a, g);
        rq = (v > 8'd119) ? "R9" : "R8";
        check(n_pulses == base + 4, poke ? "R10" : "R7", n_pulses - base, 4, "pulses per note");
        check(pd[base] == 8'h80 && prs[base] == 1'b0, "R7", int'(pd[base]), 128, "home command");
        check(pd[base+1] == l && prs[base+1] == 1'b1, rq, int'(pd[base+1]), int'(l), "letter");
        check(pd[base+2] == a && prs[base+2] == 1'b1, rq, int'(pd[base+2]), int'(a), "accidental");
        check(pd[base+3] == g && prs[base+3] == 1'b1, rq, int'(pd[base+3]), int'(g), "digit");
    endtask

    logic [7:0] init_exp [0:8];

    initial begin
        int seed;
        init_exp[0] = 8'h30; init_exp[1] = 8'h30; init_exp[2] = 8'h30;
        init_exp[3] = 8'h38; init_exp[4] = 8'h08; init_exp[5] = 8'h01;
        init_exp[6] = 8'h06; init_exp[7] = 8'h0C; init_exp[8] = 8'h74;
        seed = int'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        rel_cyc = cyc;
        @(negedge clk);
        // R1: reset state
        check(lcd_en === 1'b0, "R1", int'(lcd_en), 0, "enable low after reset");
        check(busy === 1'b1, "R1", int'(busy), 1, "busy during setup");
        // R10: strobe during setup
        repeat (200) @(negedge clk);
        rx_byte = 8'h05;
        rx_done = 1'b1;
        @(negedge clk);
        rx_done = 1'b0;
        wait_idle();
        check(n_pulses == 9, "R2", n_pulses, 9, "setup pulse count");
        check(prise[0] - rel_cyc >= T_PWRUP, "R1", prise[0] - rel_cyc, T_PWRUP, "power-on delay");
        for (int i = 0; i < 8; i++)
            check(pd[i] == init_exp[i] && prs[i] == 1'b0, "R2", int'(pd[i]), int'(init_exp[i]), "setup command");
        check(pd[8] == 8'h74 && prs[8] == 1'b1, "R3", int'(pd[8]), 116, "setup final data write");
        repeat (300) @(negedge clk);
        check(n_pulses == 9, "R3", n_pulses, 9, "no pulses after setup (R10 strobe ignored)");
        // Directed corners
        send_note(8'd0, 1'b0);
        send_note(8'd1, 1'b0);
        send_note(8'd11, 1'b1);
        send_note(8'd12, 1'b0);
        send_note(8'd119, 1'b0);
        send_note(8'd120, 1'b0);
        send_note(8'd255, 1'b1);
        // Random indices from a fixed seed
        for (int k = 0; k < 30; k++)
            send_note(8'($urandom % 256), ($urandom % 4) == 0);
        repeat (200) @(negedge clk);
        check(gap_bad == 0, "R4", gap_bad, 0, "short execution gaps");
        check(width_bad == 0, "R5", width_bad, 0, "enable width errors");
        check(setup_bad == 0 && hold_bad == 0, "R5", setup_bad + hold_bad, 0, "setup/hold errors");
        check(busy_bad == 0, "R11", busy_bad, 0, "pulses while idle");
        $display("%0d/%0d checks passed", n_pass, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        $display("FAIL R11 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_pass, n_chk);
        $finish;
    end

endmodule